// File: doc/BRIEF.md
# LPC Peripheral SYNC and Wait-State Engine

This block is the target-side cycle engine for a device on the Low Pin Count bus. It watches the frame strobe and the shared nibble lane for a start nibble of `0000`. It then takes the cycle type, direction and DMA size from an external decoder and counts through the host's header, write data and turnaround nibbles. After that it takes the lane and drives SYNC codes: a fixed number of wait codes set by cycle type and direction, then a ready code. On reads, the data byte follows.

I/O cycles wait with `0110` and DMA cycles wait with `0101`. An I/O cycle that the decoder marks as slow holds `0110` until the device signals ready or error, and the wait is bounded by a timeout. Errors are reported with `1010`. A DMA cycle of several bytes runs one SYNC sequence per byte and stops at the first error. Any frame strobe seen after the start phase abandons the cycle and releases the lane.

Top module: `lpc_sync_engine`

## Requirements
- R1: While `rst_n` is low, `lad_oe` is 0 and `ldrq_n` is 1 whatever `lframe_n` and `lad_in` do. After reset, no cycle is active until a new start is seen.
- R2: A cycle begins only when `lframe_n` is low with `lad_in` = `0000`. The nibble in the first clock with `lframe_n` high is the cycle-type nibble. A start nibble of any other value leaves the lane undriven.
- R3: An I/O read drives wait code `0110` for 3 clocks and an I/O write drives it for 2 clocks before the ready code.
- R4: A DMA read drives wait code `0101` for 3 clocks and a DMA write drives it for 4 clocks before the ready code.
- R5: The ready code is `0000`. On a read, the next two clocks carry `rd_data[3:0]` and then `rd_data[7:4]`, where `rd_data` is sampled in the clock the ready or error code is driven.
- R6: After the last SYNC or data nibble, the block drives `1111` for one clock, releases the lane (`lad_oe` = 0) in the next clock, and returns to idle.
- R7: An I/O cycle with `dec_slow` = 1 drives `0110` until `dev_ready` is 1 and then drives `0000` in that same clock. `dec_slow` and `dev_ready` have no effect on DMA cycles or on non-slow cycles.
- R8: A slow I/O cycle that has driven `0110` for 330 clocks without `dev_ready` drives the error code `1010` in the next clock.
- R9: `dev_err` = 1 during any SYNC clock makes that clock carry `1010`. A read still delivers its two data nibbles after the error code. The cycle then ends with the turnaround of R6.
- R10: DMA byte count comes from `dec_size`: `01` gives 2 bytes, `11` gives 4 bytes, and any other value gives 1 byte. Each byte gets its own SYNC sequence (and data nibbles on a read). An error code ends the cycle with no further bytes.
- R11: If `lframe_n` goes low in any phase after the start phase, `lad_oe` is 0 from the next clock and the cycle is abandoned.
- R12: Between the cycle-type nibble and the first SYNC clock, the host owns the lane for 4 address nibbles (I/O) or 2 channel/size nibbles (DMA), plus 2 data nibbles per byte on writes, plus 2 turnaround clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lframe_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble lane as seen at the pins |
| lad_out | output | 4 | Nibble driven onto the lane |
| lad_oe | output | 1 | Drive enable for the lane |
| ldrq_n | output | 1 | DMA request line, held inactive high |
| dec_dma | input | 1 | Decoder: 1 = DMA cycle, 0 = I/O cycle |
| dec_wr | input | 1 | Decoder: 1 = host writes, 0 = host reads |
| dec_size | input | 2 | Decoder: DMA transfer size code |
| dec_slow | input | 1 | Decoder: I/O target needs the ready-gated long wait |
| rd_data | input | 8 | Byte returned on reads |
| dev_ready | input | 1 | Slow target has finished |
| dev_err | input | 1 | Target reports a failure |

## Verification
The bench drives the host side of every cycle and predicts each lane nibble from cycle type, direction, size and the clock at which ready or error is raised. It checks the exact wait length for each of the four type/direction pairs: an off-by-one counter would put the ready code one clock early or late. A long wait with ready withheld must reach the 330-clock timeout, where a missing bound hangs on `0110` and a wrong bound errors at the wrong clock. Errors are placed on middle bytes of 2- and 4-byte DMA transfers to catch an engine that keeps transferring after `1010` or that drops the data nibbles of a failed read. Frame aborts in header and SYNC phases, a non-zero start nibble, and ready pulses on non-slow cycles check that the lane stays released and that the pulses are ignored.

// File: rtl/lpc_sync_engine.sv
module lpc_sync_engine #(
  parameter int IO_RD_WAIT  = 3,
  parameter int IO_WR_WAIT  = 2,
  parameter int DMA_RD_WAIT = 3,
  parameter int DMA_WR_WAIT = 4,
  parameter int LONG_MAX    = 330
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lframe_n,
  input  logic [3:0] lad_in,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  output logic       ldrq_n,
  input  logic       dec_dma,
  input  logic       dec_wr,
  input  logic [1:0] dec_size,
  input  logic       dec_slow,
  input  logic [7:0] rd_data,
  input  logic       dev_ready,
  input  logic       dev_err
);

  localparam int CW = $clog2(LONG_MAX + 1);
  localparam logic [CW-1:0] W_IORD  = CW'(IO_RD_WAIT);
  localparam logic [CW-1:0] W_IOWR  = CW'(IO_WR_WAIT);
  localparam logic [CW-1:0] W_DMARD = CW'(DMA_RD_WAIT);
  localparam logic [CW-1:0] W_DMAWR = CW'(DMA_WR_WAIT);
  localparam logic [CW-1:0] W_MAX   = CW'(LONG_MAX);
  localparam logic [3:0] C_RDY   = 4'b0000;
  localparam logic [3:0] C_SHORT = 4'b0101;
  localparam logic [3:0] C_LONG  = 4'b0110;
  localparam logic [3:0] C_ERR   = 4'b1010;
  localparam logic [3:0] C_TAR   = 4'b1111;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_HDR, S_SYNC, S_DLO, S_DHI, S_TAR1, S_TAR2
  } st_t;

  st_t           st;
  logic          is_dma, is_wr, slow, err_seen;
  logic [2:0]    left;
  logic [3:0]    hcnt;
  logic [CW-1:0] wcnt;
  logic [7:0]    dbyte;

  logic [CW-1:0] waits;
  logic [2:0]    nb_dec;
  logic [3:0]    hdr_len;
  logic          timeout, sync_err, sync_done, last, abort;
  logic [3:0]    sync_code;

  assign waits   = is_dma ? (is_wr ? W_DMAWR : W_DMARD) : (is_wr ? W_IOWR : W_IORD);
  assign nb_dec  = !dec_dma ? 3'd1 : (dec_size == 2'b11) ? 3'd4 : (dec_size == 2'b01) ? 3'd2 : 3'd1;
  assign hdr_len = (dec_dma ? 4'd2 : 4'd4) + (dec_wr ? {nb_dec, 1'b0} : 4'd0) + 4'd2;

  assign timeout   = slow && !dev_ready && (wcnt == W_MAX);
  assign sync_err  = dev_err || timeout;
  assign sync_done = sync_err || (slow ? dev_ready : (wcnt >= waits));
  assign sync_code = sync_err ? C_ERR : sync_done ? C_RDY : (is_dma ? C_SHORT : C_LONG);
  assign last      = (left == 3'd1);
  assign abort     = !lframe_n && (st != S_IDLE) && (st != S_START);

  always_comb begin
    case (st)
      S_SYNC:  lad_out = sync_code;
      S_DLO:   lad_out = dbyte[3:0];
      S_DHI:   lad_out = dbyte[7:4];
      S_TAR1:  lad_out = C_TAR;
      default: lad_out = 4'b0000;
    endcase
  end

  assign lad_oe = (st == S_SYNC) || (st == S_DLO) || (st == S_DHI) || (st == S_TAR1);
  assign ldrq_n = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      is_dma   <= 1'b0;
      is_wr    <= 1'b0;
      slow     <= 1'b0;
      err_seen <= 1'b0;
      left     <= 3'd0;
      hcnt     <= 4'd0;
      wcnt     <= '0;
      dbyte    <= 8'h00;
    end else if (abort) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:
          if (!lframe_n && lad_in == 4'b0000) st <= S_START;
        S_START:
          if (!lframe_n) begin
            st <= (lad_in == 4'b0000) ? S_START : S_IDLE;
          end else begin
            is_dma   <= dec_dma;
            is_wr    <= dec_wr;
            slow     <= dec_slow && !dec_dma;
            left     <= nb_dec;
            hcnt     <= hdr_len;
            err_seen <= 1'b0;
            st       <= S_HDR;
          end
        S_HDR:
          if (hcnt == 4'd1) begin
            wcnt <= '0;
            st   <= S_SYNC;
          end else begin
            hcnt <= hcnt - 4'd1;
          end
        S_SYNC:
          if (sync_done) begin
            err_seen <= sync_err;
            dbyte    <= rd_data;
            if (!is_wr) begin
              st <= S_DLO;
            end else if (sync_err || last) begin
              st <= S_TAR1;
            end else begin
              left <= left - 3'd1;
              wcnt <= '0;
            end
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        S_DLO:
          st <= S_DHI;
        S_DHI:
          if (err_seen || last) begin
            st <= S_TAR1;
          end else begin
            left <= left - 3'd1;
            wcnt <= '0;
            st   <= S_SYNC;
          end
        S_TAR1:  st <= S_TAR2;
        default: st <= S_IDLE;
      endcase
    end
  end

  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (!lad_oe && ldrq_n);
  end

  a_r3_sync_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SYNC) |-> (lad_oe && (lad_out == C_RDY || lad_out == C_SHORT ||
                                   lad_out == C_LONG || lad_out == C_ERR)));

  a_r5_data_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SYNC && sync_done && !is_wr && lframe_n) |=>
      (lad_oe && lad_out == $past(rd_data[3:0])));

  a_r6_tar_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DHI && lframe_n && (err_seen || last)) |=> (lad_oe && lad_out == C_TAR));

  a_r6_tar_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAR1) |=> !lad_oe);

  a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= W_MAX);

  a_r10_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SYNC && sync_err && is_wr && lframe_n) |=> (st == S_TAR1));

  a_r11_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !lad_oe);

endmodule

// File: tb/lpc_sync_engine_tb_top.sv
module lpc_sync_engine_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lframe_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic       lad_oe, ldrq_n;
  logic       dec_dma = 1'b0, dec_wr = 1'b0, dec_slow = 1'b0;
  logic [1:0] dec_size = 2'b00;
  logic [7:0] rd_data = 8'h00;
  logic       dev_ready = 1'b0, dev_err = 1'b0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lpc_sync_engine dut_i (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .ldrq_n(ldrq_n),
    .dec_dma(dec_dma), .dec_wr(dec_wr), .dec_size(dec_size), .dec_slow(dec_slow),
    .rd_data(rd_data), .dev_ready(dev_ready), .dev_err(dev_err)
  );

  function automatic int nbytes(input logic dma, input logic [1:0] sz);
    if (!dma) return 1;
    if (sz == 2'b11) return 4;
    if (sz == 2'b01) return 2;
    return 1;
  endfunction

  function automatic int fixed_waits(input logic dma, input logic wr);
    if (dma) return wr ? 4 : 3;
    return wr ? 2 : 3;
  endfunction

  function automatic logic [3:0] exp_sync(input logic dma, input logic wr, input logic slw,
                                          input int w, input logic rdy, input logic er);
    if (er) return 4'b1010;
    if (slw) begin
      if (rdy) return 4'b0000;
      if (w == 330) return 4'b1010;
      return 4'b0110;
    end
    if (w < fixed_waits(dma, wr)) return dma ? 4'b0101 : 4'b0110;
    return 4'b0000;
  endfunction

  task automatic chk(input string req, input logic oe_e, input logic [3:0] d_e);
    total++;
    if (lad_oe !== oe_e || (oe_e && lad_out !== d_e)) begin
      bad++;
      $display("FAIL %s: oe=%b lad=%h expected oe=%b lad=%h at %0t",
               req, lad_oe, lad_out, oe_e, d_e, $time);
    end
  endtask

  task automatic idle_clocks(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lframe_n = 1'b1; lad_in = 4'hF; dev_ready = 1'b0; dev_err = 1'b0;
      #1 chk(req, 1'b0, 4'h0);
    end
  endtask

  task automatic host_header(input logic dma, input logic wr, input logic [1:0] sz,
                             input logic slw, input logic [7:0] d);
    int h;
    @(negedge clk);
    lframe_n = 1'b0; lad_in = 4'h0;
    dec_dma = dma; dec_wr = wr; dec_size = sz; dec_slow = slw; rd_data = d;
    #1 chk("R2", 1'b0, 4'h0);
    @(negedge clk);
    lframe_n = 1'b1; lad_in = {2'b00, wr, 1'b0};
    #1 chk("R2", 1'b0, 4'h0);
    h = (dma ? 2 : 4) + (wr ? 2 * nbytes(dma, sz) : 0) + 2;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      lad_in = 4'($urandom);
      #1 chk("R12", 1'b0, 4'h0);
    end
  endtask

  task automatic run_cycle(input logic dma, input logic wr, input logic [1:0] sz,
                           input logic slw, input int rdy_after, input int err_byte,
                           input int err_after, input logic [7:0] d);
    int nb;
    logic slw_eff;
    logic erred;
    string rq;
    nb = nbytes(dma, sz);
    slw_eff = slw && !dma;
    erred = 1'b0;
    host_header(dma, wr, sz, slw, d);
    for (int b = 0; b < nb && !erred; b++) begin
      int w;
      logic done;
      logic [3:0] e;
      w = 0; done = 1'b0;
      while (!done) begin
        @(negedge clk);
        lad_in = 4'hF;
        dev_ready = (w == rdy_after);
        dev_err = (b == err_byte) && (w == err_after);
        e = exp_sync(dma, wr, slw_eff, w, dev_ready, dev_err);
        if (e == 4'b1010) rq = (slw_eff && !dev_err) ? "R8" : (nb > 1 ? "R10" : "R9");
        else if (slw_eff) rq = "R7";
        else if (e == 4'b0000) rq = "R5";
        else rq = dma ? "R4" : "R3";
        #1 chk(rq, 1'b1, e);
        if (e == 4'b0101 || e == 4'b0110) w++;
        else begin
          done = 1'b1;
          erred = (e == 4'b1010);
        end
      end
      if (!wr) begin
        @(negedge clk); dev_ready = 1'b0; dev_err = 1'b0;
        #1 chk(erred ? "R9" : "R5", 1'b1, d[3:0]);
        @(negedge clk);
        #1 chk(erred ? "R9" : "R5", 1'b1, d[7:4]);
      end
    end
    @(negedge clk); dev_ready = 1'b0; dev_err = 1'b0;
    #1 chk(erred ? "R10" : "R6", 1'b1, 4'hF);
    @(negedge clk);
    #1 chk("R6", 1'b0, 4'h0);
    idle_clocks("R6", 1);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    lframe_n = 1'b0; lad_in = 4'h0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      total++;
      if (lad_oe !== 1'b0 || ldrq_n !== 1'b1) begin
        bad++;
        $display("FAIL R1: oe=%b ldrq_n=%b expected oe=0 ldrq_n=1", lad_oe, ldrq_n);
      end
    end
    @(negedge clk);
    rst_n = 1'b1; lframe_n = 1'b1; lad_in = 4'hF;
    #1 chk("R1", 1'b0, 4'h0);
    idle_clocks("R1", 6);

    run_cycle(1'b0, 1'b0, 2'b00, 1'b0, -1, -1, -1, 8'hA5);
    run_cycle(1'b0, 1'b1, 2'b00, 1'b0, -1, -1, -1, 8'h3C);
    run_cycle(1'b1, 1'b0, 2'b00, 1'b0, -1, -1, -1, 8'h96);
    run_cycle(1'b1, 1'b1, 2'b00, 1'b0, -1, -1, -1, 8'h00);
    run_cycle(1'b0, 1'b0, 2'b00, 1'b0,  0, -1, -1, 8'h5A);
    run_cycle(1'b1, 1'b0, 2'b01, 1'b1,  0, -1, -1, 8'hE1);
    run_cycle(1'b0, 1'b0, 2'b00, 1'b1, 10, -1, -1, 8'h7E);
    run_cycle(1'b0, 1'b1, 2'b00, 1'b1,  0, -1, -1, 8'h11);
    run_cycle(1'b0, 1'b0, 2'b00, 1'b1, -1, -1, -1, 8'hC3);
    run_cycle(1'b0, 1'b1, 2'b00, 1'b1, 329, -1, -1, 8'h22);
    run_cycle(1'b0, 1'b0, 2'b00, 1'b0, -1,  0,  1, 8'h4B);
    run_cycle(1'b1, 1'b0, 2'b11, 1'b0, -1, -1, -1, 8'hD2);
    run_cycle(1'b1, 1'b0, 2'b11, 1'b0, -1,  1,  2, 8'h69);
    run_cycle(1'b1, 1'b1, 2'b01, 1'b0, -1,  0,  0, 8'h00);
    run_cycle(1'b1, 1'b1, 2'b11, 1'b0, -1,  2,  4, 8'h00);
    run_cycle(1'b1, 1'b0, 2'b10, 1'b0, -1, -1, -1, 8'h88);

    @(negedge clk); lframe_n = 1'b0; lad_in = 4'b0101;
    #1 chk("R2", 1'b0, 4'h0);
    idle_clocks("R2", 20);

    host_header(1'b0, 1'b0, 2'b00, 1'b0, 8'h31);
    @(negedge clk); lad_in = 4'hF;
    #1 chk("R3", 1'b1, 4'b0110);
    @(negedge clk); lframe_n = 1'b0;
    @(negedge clk); lframe_n = 1'b1;
    #1 chk("R11", 1'b0, 4'h0);
    idle_clocks("R11", 8);

    @(negedge clk);
    lframe_n = 1'b0; lad_in = 4'h0; dec_dma = 1'b1; dec_wr = 1'b0; dec_size = 2'b00;
    @(negedge clk); lframe_n = 1'b1; lad_in = 4'h2;
    @(negedge clk); lad_in = 4'h1;
    @(negedge clk); lframe_n = 1'b0; lad_in = 4'hF;
    @(negedge clk); lframe_n = 1'b1;
    #1 chk("R11", 1'b0, 4'h0);
    idle_clocks("R11", 10);

    for (int n = 0; n < 30; n++) begin
      logic dma, wr, slw;
      logic [1:0] sz;
      int nb, ra, eb, ea;
      dma = 1'($urandom); wr = 1'($urandom); slw = 1'($urandom); sz = 2'($urandom);
      nb = nbytes(dma, sz);
      ra = (slw && !dma) ? int'($urandom % 20) : int'($urandom % 3);
      eb = -1; ea = -1;
      if ($urandom % 4 == 0) begin
        eb = int'($urandom % nb);
        ea = int'($urandom % 4);
      end
      run_cycle(dma, wr, sz, slw, ra, eb, ea, 8'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule